// File: doc/BRIEF.md
# Iterative AES-128 Encryption Core

This block encrypts a single 128-bit block under a 128-bit cipher key. It follows the AES-128 forward cipher. One round circuit is reused for all ten rounds, one round per clock. Each round key is derived from the previous one in the same cycle it is consumed, so no expanded key schedule is ever stored. All byte substitutions are computed in logic, with no lookup memory.

A user presents a plaintext and a key together with a one-cycle `start` while `busy` is low. The core then works on that block alone and ignores further starts. When the last round completes, it raises `done` for one cycle and places the ciphertext on `cipherOut`. That value stays put until the next block finishes.

Bytes are packed most-significant first. Bits [127:120] are byte 0, and byte index `i` sits at row `i % 4`, column `i / 4` of the state matrix. The key uses the same packing.

Top module: `aesIterCore`

## Requirements
- R1: While `rstN` is low and after its release, with no start, `busy` and `done` are 0 and `cipherOut` is all zeros.
- R2: A `start` sampled high at a rising edge while `busy` is low is accepted, and `busy` is 1 in the following cycle.
- R3: For an accepted block, the value in `cipherOut` when `done` is high equals the AES-128 encryption of `plainIn` under `keyIn`, both sampled at the accepting edge. The byte packing is as stated above, for example key 000102…0f and plaintext 00112233…ff give 69c4e0d86a7b0430d8cdb78070b4c55a.
- R4: `done` is high for exactly one cycle, the cycle after the 10th rising edge following the accepting edge (11 cycles counted from the accepting cycle), and `busy` is 0 in that cycle.
- R5: `busy` stays 1 in each of the 10 cycles after the accepting edge, up to but excluding the `done` cycle.
- R6: A `start` sampled while `busy` is 1 has no effect: the running block's result and timing are unchanged, and no extra `done` follows.
- R7: `cipherOut` changes only in the cycle `done` rises. It holds the previous ciphertext during the next block's rounds and after completion.
- R8: A new `start` may be presented in the very cycle `done` is high. Blocks issued back to back this way each produce their correct ciphertext on schedule.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to encrypt; accepted only when `busy` is low |
| plainIn | input | 128 | Plaintext block, sampled at the accepting edge |
| keyIn | input | 128 | Cipher key, sampled at the accepting edge |
| busy | output | 1 | High while a block is being processed |
| done | output | 1 | One-cycle pulse when the ciphertext is ready |
| cipherOut | output | 128 | Last produced ciphertext |

## Verification
The cipher diffuses strongly, so a wrong internal value shows at the ports as a ciphertext that differs in roughly half its bits. This holds for a bad substitution byte, a misrouted row shift, a wrong mixing coefficient, or a round constant that fails to wrap from 0x80 to 0x1B. Such errors show in the single `done` cycle 11 cycles after acceptance. A miscounting round counter shows sooner and more directly: `done` arrives at the wrong cycle, `busy` drops early, or a second pulse appears. The bench therefore times every `done` against its start and compares every result with an independent model, across known vectors and varied patterns.

// File: rtl/aesIterPkg.sv
package aesIterPkg;

  localparam int BlockBits = 128;
  localparam int KeyBits   = 128;
  localparam int NumRounds = 10;
  localparam int CntBits   = $clog2(NumRounds + 1);
  localparam int ByteCnt   = BlockBits / 8;
  localparam int WordCnt   = KeyBits / 32;
  localparam int RowCnt    = 4;
  localparam int ColCnt    = BlockBits / (8 * RowCnt);

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadInit;   // latch plaintext xor key, seed round key and constant
    logic doRound;    // apply one round and advance the key
    logic lastRound;  // this round omits column mixing and publishes output
  } strobeT;

  // Multiply by x in GF(2^8) modulo x^8+x^4+x^3+x+1
  function automatic logic [7:0] gfDouble(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gfMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] p;
    acc = 8'h00;
    p   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ p;
      p = gfDouble(p);
    end
    return acc;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int k);
    return (v << k) | (v >> (8 - k));
  endfunction

  // Substitution: inverse as a^254 by repeated squaring, then affine map
  function automatic logic [7:0] sboxCalc(input logic [7:0] x);
    logic [7:0] sq;
    logic [7:0] acc;
    sq  = x;
    acc = 8'h01;
    for (int i = 1; i < 8; i++) begin
      sq  = gfMul(sq, sq);
      acc = gfMul(acc, sq);
    end
    return acc ^ rotl8(acc, 1) ^ rotl8(acc, 2) ^ rotl8(acc, 3) ^ rotl8(acc, 4) ^ 8'h63;
  endfunction

endpackage

// File: rtl/aesIterSbox.sv
module aesIterSbox
  import aesIterPkg::*;
(
  input  logic [7:0] inByte,
  output logic [7:0] outByte
);
  assign outByte = sboxCalc(inByte);
endmodule

// File: rtl/aesIterCtrl.sv
module aesIterCtrl
  import aesIterPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  output strobeT stb,
  output logic   busy,
  output logic   done
);

  logic [CntBits-1:0] roundCnt;

  always_comb begin
    stb.loadInit  = start && !busy;
    stb.doRound   = busy;
    stb.lastRound = busy && (roundCnt == CntBits'(NumRounds));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      roundCnt <= '0;
    end else begin
      done <= stb.lastRound;
      if (stb.loadInit) begin
        busy     <= 1'b1;
        roundCnt <= CntBits'(1);
      end else if (stb.doRound) begin
        if (stb.lastRound) begin
          busy     <= 1'b0;
          roundCnt <= '0;
        end else begin
          roundCnt <= roundCnt + 1'b1;
        end
      end
    end
  end

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_busy_held_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !stb.lastRound) |=> busy);

  assert_count_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (roundCnt != '0 && roundCnt <= CntBits'(NumRounds)));

endmodule

// File: rtl/aesIterPath.sv
module aesIterPath
  import aesIterPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobeT               stb,
  input  logic [BlockBits-1:0] plainIn,
  input  logic [KeyBits-1:0]   keyIn,
  output logic [BlockBits-1:0] cipherOut
);

  logic [BlockBits-1:0] stateQ;
  logic [KeyBits-1:0]   roundKeyQ;
  logic [7:0]           rconQ;

  logic [BlockBits-1:0] subbed;
  logic [BlockBits-1:0] shifted;
  logic [BlockBits-1:0] mixed;
  logic [BlockBits-1:0] roundOut;
  logic [KeyBits-1:0]   nextKey;
  logic [31:0]          rotWord;
  logic [31:0]          subWord;

  // Byte substitution over the whole state
  for (genvar i = 0; i < ByteCnt; i++) begin : gSub
    aesIterSbox uSbox (
      .inByte (stateQ[BlockBits-1-8*i -: 8]),
      .outByte(subbed[BlockBits-1-8*i -: 8])
    );
  end

  // Row r rotates left by r positions: (r,c) takes (r,(c+r)%cols)
  for (genvar c = 0; c < ColCnt; c++) begin : gShiftCol
    for (genvar r = 0; r < RowCnt; r++) begin : gShiftRow
      assign shifted[BlockBits-1-8*(c*RowCnt+r) -: 8] =
        subbed[BlockBits-1-8*(((c+r)%ColCnt)*RowCnt+r) -: 8];
    end
  end

  // Column mixing with the circulant (2,3,1,1)
  for (genvar c = 0; c < ColCnt; c++) begin : gMix
    logic [7:0] a0, a1, a2, a3;
    logic [7:0] d0, d1, d2, d3;
    assign a0 = shifted[BlockBits-1-32*c      -: 8];
    assign a1 = shifted[BlockBits-1-32*c-8    -: 8];
    assign a2 = shifted[BlockBits-1-32*c-16   -: 8];
    assign a3 = shifted[BlockBits-1-32*c-24   -: 8];
    assign d0 = gfDouble(a0);
    assign d1 = gfDouble(a1);
    assign d2 = gfDouble(a2);
    assign d3 = gfDouble(a3);
    assign mixed[BlockBits-1-32*c -: 32] = {
      d0 ^ d1 ^ a1 ^ a2 ^ a3,
      a0 ^ d1 ^ d2 ^ a2 ^ a3,
      a0 ^ a1 ^ d2 ^ d3 ^ a3,
      d0 ^ a0 ^ a1 ^ a2 ^ d3
    };
  end

  // On-the-fly key step: rotate last word, substitute, add constant, chain
  assign rotWord = {roundKeyQ[23:0], roundKeyQ[31:24]};

  for (genvar b = 0; b < 4; b++) begin : gKeySub
    aesIterSbox uKeySbox (
      .inByte (rotWord[31-8*b -: 8]),
      .outByte(subWord[31-8*b -: 8])
    );
  end

  always_comb begin
    logic [31:0] carry;
    carry = subWord ^ {rconQ, 24'h000000};
    for (int k = 0; k < WordCnt; k++) begin
      carry = carry ^ roundKeyQ[KeyBits-1-32*k -: 32];
      nextKey[KeyBits-1-32*k -: 32] = carry;
    end
  end

  assign roundOut = (stb.lastRound ? shifted : mixed) ^ nextKey;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= '0;
      roundKeyQ <= '0;
      rconQ     <= 8'h00;
      cipherOut <= '0;
    end else if (stb.loadInit) begin
      stateQ    <= plainIn ^ keyIn;
      roundKeyQ <= keyIn;
      rconQ     <= 8'h01;
    end else if (stb.doRound) begin
      stateQ    <= roundOut;
      roundKeyQ <= nextKey;
      rconQ     <= gfDouble(rconQ);
      if (stb.lastRound) cipherOut <= roundOut;
    end
  end

  assert_key_seed_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadInit |=> (roundKeyQ == $past(keyIn) && rconQ == 8'h01));

  assert_rcon_live_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.doRound |-> (rconQ != 8'h00));

  assert_cipher_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !stb.lastRound |=> $stable(cipherOut));

endmodule

// File: rtl/aesIterCore.sv
module aesIterCore
  import aesIterPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [BlockBits-1:0] plainIn,
  input  logic [KeyBits-1:0]   keyIn,
  output logic                 busy,
  output logic                 done,
  output logic [BlockBits-1:0] cipherOut
);

  strobeT stb;

  aesIterCtrl uCtrl (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .stb  (stb),
    .busy (busy),
    .done (done)
  );

  aesIterPath uPath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .plainIn  (plainIn),
    .keyIn    (keyIn),
    .cipherOut(cipherOut)
  );

endmodule

// File: tb/aesIterCore_test.sv
module aesIterCore_test;

  localparam int ClkPeriod = 10;

  logic         clk = 1'b0;
  logic         rstN;
  logic         start;
  logic [127:0] plainIn;
  logic [127:0] keyIn;
  logic         busy;
  logic         done;
  logic [127:0] cipherOut;

  int testCnt = 0;
  int failCnt = 0;
  int cyc = 0;
  int extraDone = 0;

  logic [127:0] expQ[$];
  int           cycQ[$];
  string        tagQ[$];

  aesIterCore uut (
    .clk(clk), .rstN(rstN), .start(start), .plainIn(plainIn), .keyIn(keyIn),
    .busy(busy), .done(done), .cipherOut(cipherOut)
  );

  always #(ClkPeriod/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- independent reference model ----------------
  function automatic logic [7:0] mMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 0;
    logic [7:0] x = a;
    logic [7:0] y = b;
    while (y != 0) begin
      if (y[0]) r ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
      y = y >> 1;
    end
    return r;
  endfunction

  function automatic logic [7:0] mSbox(input logic [7:0] x);
    logic [7:0] inv = 0;
    logic [7:0] o;
    for (int y = 1; y < 256; y++)
      if (mMul(x, 8'(y)) == 8'h01) inv = 8'(y);
    for (int i = 0; i < 8; i++)
      o[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8]
             ^ ((8'h63 >> i) & 1'b1);
    return o;
  endfunction

  function automatic logic [127:0] refEnc(input logic [127:0] pt, input logic [127:0] key);
    logic [31:0] w[44];
    logic [7:0]  s[16];
    logic [7:0]  t[16];
    logic [7:0]  rc = 8'h01;
    logic [31:0] tmp;
    logic [127:0] res;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      tmp = w[i-1];
      if (i % 4 == 0) begin
        tmp = {mSbox(tmp[23:16]), mSbox(tmp[15:8]), mSbox(tmp[7:0]), mSbox(tmp[31:24])}
              ^ {rc, 24'h0};
        rc = mMul(rc, 8'h02);
      end
      w[i] = w[i-4] ^ tmp;
    end
    for (int i = 0; i < 16; i++) s[i] = pt[127-8*i -: 8] ^ w[i/4][31-8*(i%4) -: 8];
    for (int rnd = 1; rnd <= 10; rnd++) begin
      for (int i = 0; i < 16; i++) s[i] = mSbox(s[i]);
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++) t[c*4+r] = s[((c+r)%4)*4+r];
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++)
          if (rnd < 10)
            s[c*4+r] = mMul(t[c*4+r], 8'h02) ^ mMul(t[c*4+(r+1)%4], 8'h03)
                       ^ t[c*4+(r+2)%4] ^ t[c*4+(r+3)%4];
          else
            s[c*4+r] = t[c*4+r];
      for (int i = 0; i < 16; i++) s[i] ^= w[rnd*4+i/4][31-8*(i%4) -: 8];
    end
    for (int i = 0; i < 16; i++) res[127-8*i -: 8] = s[i];
    return res;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // ---------------- driver ----------------
  // Called at a negedge; start is sampled at the next posedge.
  task automatic issue(input logic [127:0] pt, input logic [127:0] key,
                       input logic [127:0] exp, input string tag);
    start   = 1'b1;
    plainIn = pt;
    keyIn   = key;
    expQ.push_back(exp);
    cycQ.push_back(cyc + 11);
    tagQ.push_back(tag);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic poke(input logic [127:0] pt, input logic [127:0] key);
    start   = 1'b1;
    plainIn = pt;
    keyIn   = key;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
  endtask

  // ---------------- monitor ----------------
  always @(negedge clk) begin
    if (rstN && done) begin
      if (expQ.size() == 0) begin
        extraDone++;
      end else begin
        logic [127:0] e;
        int c;
        string t;
        e = expQ.pop_front();
        c = cycQ.pop_front();
        t = tagQ.pop_front();
        check(cipherOut == e, {t, " ciphertext"}, cipherOut, e);
        check(cyc == c, "R4 done latency", 128'(cyc), 128'(c));
      end
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [127:0] kA, pA, cA, kB, pB, cB, cZ, p, k;
    bit okBusy;
    kA = 128'h000102030405060708090a0b0c0d0e0f;
    pA = 128'h00112233445566778899aabbccddeeff;
    cA = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
    kB = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    pB = 128'h3243f6a8885a308d313198a2e0370734;
    cB = 128'h3925841d02dc09fbdc118597196a0b32;
    cZ = 128'h66e94bd4ef8a2c3b884cfa59ca342b2e;

    rstN = 1'b0; start = 1'b0; plainIn = '0; keyIn = '0;
    repeat (3) @(negedge clk);
    check(!busy && !done && cipherOut == '0, "R1 outputs in reset",
          {busy, done, cipherOut[125:0]}, 128'h0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !done && cipherOut == '0, "R1 idle after reset",
          {busy, done, cipherOut[125:0]}, 128'h0);

    // Known vector A with cycle-by-cycle busy check (R2, R3, R5)
    issue(pA, kA, cA, "R3 vector A");
    check(busy == 1'b1, "R2 busy after accept", 128'(busy), 128'h1);
    okBusy = 1'b1;
    for (int n = 0; n < 9; n++) begin
      @(negedge clk);
      if (!busy || done) okBusy = 1'b0;
    end
    check(okBusy, "R5 busy held for ten cycles", 128'(okBusy), 128'h1);
    @(negedge clk);
    check(done && !busy, "R4 done with busy low", {busy, done}, 128'h1);
    @(negedge clk);
    check(!done, "R4 done single cycle", 128'(done), 128'h0);

    // Known vector B with starts while busy (R6)
    issue(pB, kB, cB, "R3 R6 vector B under ignored starts");
    repeat (2) @(negedge clk);
    poke(rnd128(), rnd128());
    @(negedge clk);
    start = 1'b1; plainIn = '0; keyIn = '0;
    repeat (2) @(negedge clk);
    start = 1'b0;
    drain();
    repeat (15) @(negedge clk);
    check(extraDone == 0, "R6 no extra done from ignored start", 128'(extraDone), 128'h0);
    check(cipherOut == cB, "R7 holds after completion", cipherOut, cB);

    // Output held during the next block (R7), zero vector (R3)
    issue('0, '0, cZ, "R3 zero vector");
    repeat (5) @(negedge clk);
    check(cipherOut == cB, "R7 holds during next rounds", cipherOut, cB);
    drain();
    repeat (8) @(negedge clk);
    check(cipherOut == cZ, "R7 holds new result", cipherOut, cZ);

    // Back-to-back blocks started in the done cycle (R8)
    for (int n = 0; n < 4; n++) begin
      p = rnd128(); k = rnd128();
      issue(p, k, refEnc(p, k), "R8 back-to-back");
      repeat (10) @(negedge clk);
    end
    drain();

    // Varied patterns with idle gaps (R3)
    for (int n = 0; n < 5; n++) begin
      case (n)
        0: begin p = '1; k = '1; end
        1: begin p = 128'h80000000000000000000000000000000; k = '0; end
        2: begin p = '0; k = 128'h00000000000000000000000000000001; end
        default: begin p = rnd128(); k = rnd128(); end
      endcase
      issue(p, k, refEnc(p, k), "R3 pattern");
      drain();
      repeat (n % 3) @(negedge clk);
    end

    repeat (15) @(negedge clk);
    check(expQ.size() == 0, "R4 every block reported done", 128'(expQ.size()), 128'h0);
    check(extraDone == 0, "R6 no spurious done overall", 128'(extraDone), 128'h0);

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule